// File: doc/BRIEF.md
# ADC Sample DMA Interrupt Controller

This block sits between an analog-to-digital converter and system memory. Each time the converter presents a signed sample, the block multiplies it by a programmable unsigned fixed-point gain and clamps the result to the signed 16-bit range. When the buffer engine is enabled, it writes the corrected value into a circular buffer described by a base address and an entry count. When the engine is disabled, the sample is dropped and the drop is recorded.

Four sticky event flags capture what happened: a dropped sample, a clamped result, a write to the final buffer entry, and a write to the final entry of the first half of the buffer. Software reads the flags through a small register port and clears them by writing ones. A mask register selects which flags may raise the single interrupt request. Polled use works with the mask left at zero.

Top module: `adc_sample_dma_irq`

## Requirements
- R1: After reset the flags, the mask, the interrupt line and the write strobe are all 0.
- R2: A sample with `sample_valid`=1 while `dma_en`=1 produces, on the next clock, `mem_we`=1 and `mem_addr` = `buf_base` + current offset, modulo 2^ADDR_W. The offset then advances by one.
- R3: `mem_wdata` equals floor(sample × gain / 32768), where the sample is signed 16-bit and the gain is an unsigned 16-bit value with 15 fractional bits. Results above +32767 become 0x7FFF and results below -32768 become 0x8000.
- R4: Flag bit 1 (saturation) sets for every valid sample whose corrected value needed clamping, whether or not it is stored.
- R5: Flag bit 0 (overflow) sets when `sample_valid`=1 while `dma_en`=0. That sample is not written: `mem_we` stays 0.
- R6: Flag bit 3 (half) sets when a write lands at offset `buf_len`/2 − 1.
- R7: Flag bit 2 (full) sets when a write lands at offset `buf_len` − 1. The following write goes to `buf_base`.
- R8: When `dma_en` goes from 0 to 1, the offset restarts at 0, so a sample in that same cycle is written to `buf_base`.
- R9: A register write with `reg_sel`=0 clears each flag whose `reg_wdata` bit is 1 and leaves the others unchanged. If a flag is set by an event and cleared in the same cycle, the set wins.
- R10: A register write with `reg_sel`=1 loads the mask. `reg_rdata` shows the mask when `reg_sel`=1 and the flags when `reg_sel`=0.
- R11: `irq` equals the OR of (flags AND mask) as they stood one clock earlier.
- R12: With the mask all zero, `irq` stays 0 while the flags keep updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Converter sample strobe |
| sample_data | input | SAMPLE_W | Signed two's-complement sample |
| gain_coef | input | GAIN_W | Unsigned gain, GAIN_FRAC fractional bits |
| dma_en | input | 1 | Buffer engine enable |
| buf_base | input | ADDR_W | Buffer start address |
| buf_len | input | LEN_W | Buffer entry count (even, at least 2) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects flags, 1 selects mask |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Selected register contents |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | SAMPLE_W | Corrected sample |
| irq | output | 1 | Interrupt request |

## Verification
Random samples are paired with unity, near-maximum and random gains. Unity gain separates a correct truncation from an off-by-one shift. Maximum gain drives both extremes of the sample range into the positive and negative clamps, which separates the saturation logic from the plain product. Directed runs over an eight-entry buffer place writes on the half and last offsets, on the wrap back to the base, and on a re-enable in the middle of the buffer. A random run uses a base near the top of the address space, so the address must wrap. Engine toggles, set-versus-clear collisions and mask changes show whether the flags, the drop path and the interrupt lag respond to the right events.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
    localparam int EVT_N    = 4;
    localparam int EV_OVF   = 0;
    localparam int EV_SAT   = 1;
    localparam int EV_FULL  = 2;
    localparam int EV_HALF  = 3;

    typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/adc_gain_corr.sv
module adc_gain_corr #(
    parameter int SW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 15
) (
    input  logic [SW-1:0] sample_i,
    input  logic [GW-1:0] gain_i,
    output logic [SW-1:0] result_o,
    output logic          sat_o
);
    localparam int PW = SW + GW + 1;
    localparam logic signed [PW-1:0] HI_LIM = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [PW-1:0] LO_LIM = ~HI_LIM;

    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shft;
    logic                 over_hi;
    logic                 over_lo;

    always_comb begin
        s_ext   = {{(GW+1){sample_i[SW-1]}}, sample_i};
        g_ext   = {{(SW+1){1'b0}}, gain_i};
        prod    = s_ext * g_ext;
        shft    = prod >>> FRAC;
        over_hi = shft > HI_LIM;
        over_lo = shft < LO_LIM;
        sat_o   = over_hi | over_lo;
        if (over_hi)      result_o = {1'b0, {(SW-1){1'b1}}};
        else if (over_lo) result_o = {1'b1, {(SW-1){1'b0}}};
        else              result_o = shft[SW-1:0];
    end
endmodule

// File: rtl/adc_buf_addr.sv
module adc_buf_addr #(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_en_i,
    input  logic          advance_i,
    input  logic [AW-1:0] buf_base_i,
    input  logic [LW-1:0] buf_len_i,
    output logic [AW-1:0] wr_addr_o,
    output logic          hit_half_o,
    output logic          hit_full_o
);
    typedef struct packed {
        logic [LW-1:0] off;
        logic          en_prev;
    } ptr_st_t;

    ptr_st_t       st_d, st_q;
    logic [LW-1:0] eff_off;
    logic [LW-1:0] last_off;
    logic [LW-1:0] half_off;

    always_comb begin
        st_d       = st_q;
        eff_off    = (dma_en_i && !st_q.en_prev) ? '0 : st_q.off;
        last_off   = buf_len_i - LW'(1);
        half_off   = (buf_len_i >> 1) - LW'(1);
        hit_full_o = (eff_off == last_off);
        hit_half_o = (eff_off == half_off);
        wr_addr_o  = buf_base_i + AW'(eff_off);
        st_d.en_prev = dma_en_i;
        st_d.off     = eff_off;
        if (advance_i) begin
            st_d.off = hit_full_o ? '0 : eff_off + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_evt_flags.sv
module adc_evt_flags
    import adc_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    input  logic     mask_we_i,
    input  evt_vec_t mask_i,
    output evt_vec_t flags_o,
    output evt_vec_t mask_o,
    output logic     irq_o
);
    typedef struct packed {
        evt_vec_t flags;
        evt_vec_t mask;
        logic     irq;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        if (mask_we_i) st_d.mask = mask_i;
        st_d.irq   = |(st_q.flags & st_q.mask);
        flags_o    = st_q.flags;
        mask_o     = st_q.mask;
        irq_o      = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_sample_dma_irq.sv
module adc_sample_dma_irq
    import adc_dma_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 15,
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic [GAIN_W-1:0]   gain_coef,
    input  logic                dma_en,
    input  logic [ADDR_W-1:0]   buf_base,
    input  logic [LEN_W-1:0]    buf_len,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [EVT_N-1:0]    reg_wdata,
    output logic [EVT_N-1:0]    reg_rdata,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata,
    output logic                irq
);
    typedef struct packed {
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [SAMPLE_W-1:0] data;
    } port_st_t;

    port_st_t            port_d, port_q;
    logic [SAMPLE_W-1:0] corr_val;
    logic                corr_sat;
    logic [ADDR_W-1:0]   wr_addr;
    logic                hit_half;
    logic                hit_full;
    logic                accept;
    evt_vec_t            evt_set;
    evt_vec_t            evt_clr;
    logic                mask_we;
    evt_vec_t            evt_flags;
    evt_vec_t            evt_mask;

    adc_gain_corr #(.SW(SAMPLE_W), .GW(GAIN_W), .FRAC(GAIN_FRAC)) u_gain (
        .sample_i (sample_data),
        .gain_i   (gain_coef),
        .result_o (corr_val),
        .sat_o    (corr_sat)
    );

    adc_buf_addr #(.AW(ADDR_W), .LW(LEN_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en_i   (dma_en),
        .advance_i  (accept),
        .buf_base_i (buf_base),
        .buf_len_i  (buf_len),
        .wr_addr_o  (wr_addr),
        .hit_half_o (hit_half),
        .hit_full_o (hit_full)
    );

    adc_evt_flags u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_set),
        .clr_i     (evt_clr),
        .mask_we_i (mask_we),
        .mask_i    (reg_wdata),
        .flags_o   (evt_flags),
        .mask_o    (evt_mask),
        .irq_o     (irq)
    );

    always_comb begin
        accept           = sample_valid & dma_en;
        evt_set          = '0;
        evt_set[EV_OVF]  = sample_valid & ~dma_en;
        evt_set[EV_SAT]  = sample_valid & corr_sat;
        evt_set[EV_FULL] = accept & hit_full;
        evt_set[EV_HALF] = accept & hit_half;
        evt_clr          = (reg_wr && !reg_sel) ? reg_wdata : '0;
        mask_we          = reg_wr & reg_sel;
        reg_rdata        = reg_sel ? evt_mask : evt_flags;

        port_d    = port_q;
        port_d.we = accept;
        if (accept) begin
            port_d.addr = wr_addr;
            port_d.data = corr_val;
        end
        mem_we    = port_q.we;
        mem_addr  = port_q.addr;
        mem_wdata = port_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end
endmodule

// File: rtl/adc_sample_dma_irq_chk.sv
module adc_sample_dma_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_valid,
    input logic       dma_en,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [3:0] reg_wdata,
    input logic       mem_we,
    input logic       irq,
    input logic [3:0] evt_flags,
    input logic [3:0] evt_mask
);
    logic [3:0] clr_vec;
    assign clr_vec = (reg_wr && !reg_sel) ? reg_wdata : 4'b0;

    // R2: accepted sample shows a write strobe one clock later
    a_r2_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && dma_en) |=> mem_we);

    // R5: a sample with the engine off is dropped and flagged
    a_r5_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !dma_en) |=> !mem_we);

    a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !dma_en) |=> evt_flags[0]);

    // R9: a flag can only fall after a write-one clear of its bit
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((~evt_flags & $past(evt_flags)) & ~$past(clr_vec)) == 4'b0);

    // R11: interrupt follows masked flags with one clock of lag
    a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |($past(evt_flags) & $past(evt_mask)));

    // R12: an all-zero mask keeps the line low
    a_r12_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mask == 4'b0) |=> !irq);
endmodule

bind adc_sample_dma_irq adc_sample_dma_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .dma_en       (dma_en),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .mem_we       (mem_we),
    .irq          (irq),
    .evt_flags    (evt_flags),
    .evt_mask     (evt_mask)
);

// File: tb/sim_adc_sample_dma_irq.sv
module sim_adc_sample_dma_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_valid;
    logic [15:0] sample_data;
    logic [15:0] gain_coef;
    logic        dma_en;
    logic [15:0] buf_base;
    logic [11:0] buf_len;
    logic        reg_wr;
    logic        reg_sel;
    logic [3:0]  reg_wdata;
    logic [3:0]  reg_rdata;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    int         m_off;
    logic       m_enp;
    logic [3:0] m_flags;
    logic [3:0] m_mask;
    logic       m_irq;
    logic       m_we;
    logic [15:0] m_addr;
    logic [15:0] m_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_dma_irq u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_data(sample_data), .gain_coef(gain_coef), .dma_en(dma_en),
        .buf_base(buf_base), .buf_len(buf_len), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    function automatic logic [16:0] gain_ref(input logic [15:0] s, input logic [15:0] g);
        longint p, q;
        p = longint'($signed(s)) * longint'({16'b0, g});
        q = p >>> 15;
        if (q > 32767)       return {1'b1, 16'h7FFF};
        else if (q < -32768) return {1'b1, 16'h8000};
        else                 return {1'b0, q[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [16:0] r;
        logic [3:0]  setv, clrv;
        logic        irq_n;
        int          eff;
        irq_n = |(m_flags & m_mask);
        eff   = (dma_en && !m_enp) ? 0 : m_off;
        setv  = 4'b0;
        m_we  = 1'b0;
        if (sample_valid) begin
            r = gain_ref(sample_data, gain_coef);
            if (r[16]) setv[1] = 1'b1;
            if (dma_en) begin
                m_we   = 1'b1;
                m_addr = buf_base + 16'(eff);
                m_data = r[15:0];
                if (eff == int'(buf_len) - 1)     setv[2] = 1'b1;
                if (eff == int'(buf_len) / 2 - 1) setv[3] = 1'b1;
                eff = (eff == int'(buf_len) - 1) ? 0 : eff + 1;
            end else begin
                setv[0] = 1'b1;
            end
        end
        m_off   = eff;
        m_enp   = dma_en;
        clrv    = (reg_wr && !reg_sel) ? reg_wdata : 4'b0;
        m_flags = (m_flags & ~clrv) | setv;
        if (reg_wr && reg_sel) m_mask = reg_wdata;
        m_irq   = irq_n;
    endtask

    task automatic compare();
        chk(m_we ? "R2 write strobe" : "R5 write strobe", 32'(mem_we), 32'(m_we));
        if (m_we) begin
            chk("R2 address", 32'(mem_addr), 32'(m_addr));
            chk("R3 data", 32'(mem_wdata), 32'(m_data));
        end
        chk("R11 irq", 32'(irq), 32'(m_irq));
        if (reg_sel) chk("R10 mask readback", 32'(reg_rdata), 32'(m_mask));
        else         chk("R9 flags readback (R4,R6,R7)", 32'(reg_rdata), 32'(m_flags));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(input logic v, input logic [15:0] s, input logic [15:0] g,
                         input logic en, input logic wr, input logic sel, input logic [3:0] wd);
        sample_valid = v;
        sample_data  = s;
        gain_coef    = g;
        dma_en       = en;
        reg_wr       = wr;
        reg_sel      = sel;
        reg_wdata    = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        buf_base = 16'h0100;
        buf_len  = 12'd8;
        m_off = 0; m_enp = 1'b0; m_flags = 4'h0; m_mask = 4'h0;
        m_irq = 1'b0; m_we = 1'b0; m_addr = '0; m_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 mem_we", 32'(mem_we), 32'd0);
        chk("R1 flags", 32'(reg_rdata), 32'd0);
        reg_sel = 1'b1; #1;
        chk("R1 mask", 32'(reg_rdata), 32'd0);
        reg_sel = 1'b0;

        // R6/R7: fill an 8-entry buffer at unity gain
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 16'(i * 3 + 1), 16'h8000, 1'b1, 1'b0, 1'b0, 4'h0);
            tick();
            if (i == 3) begin
                chk("R6 half flag", 32'(reg_rdata[3]), 32'd1);
                chk("R6 half address", 32'(mem_addr), 32'h0103);
                chk("R6 full not yet", 32'(reg_rdata[2]), 32'd0);
            end
            if (i == 7) begin
                chk("R7 full flag", 32'(reg_rdata[2]), 32'd1);
                chk("R7 last address", 32'(mem_addr), 32'h0107);
            end
        end
        chk("R3 unity gain", 32'(mem_wdata), 32'd22);
        drive(1'b1, 16'hFFF6, 16'h8000, 1'b1, 1'b0, 1'b0, 4'h0);
        tick();
        chk("R7 wrap to base", 32'(mem_addr), 32'h0100);
        chk("R3 negative unity", 32'(mem_wdata), 32'hFFF6);
        // R12: flags set, mask zero
        chk("R12 irq low with mask zero", 32'(irq), 32'd0);

        // R8: re-enable mid buffer
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        drive(1'b1, 16'h0005, 16'h8000, 1'b1, 1'b0, 1'b0, 4'h0);
        tick();
        chk("R8 restart at base", 32'(mem_addr), 32'h0100);

        // R4: saturation both ways
        drive(1'b1, 16'h7FFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 4'hF);
        tick();
        chk("R4 clamp high", 32'(mem_wdata), 32'h7FFF);
        chk("R4 sat flag", 32'(reg_rdata[1]), 32'd1);
        drive(1'b1, 16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b0, 4'h2);
        tick();
        chk("R4 clamp low", 32'(mem_wdata), 32'h8000);
        chk("R9 set wins over clear", 32'(reg_rdata[1]), 32'd1);

        // R9: clear all
        drive(1'b0, 16'h0, 16'h8000, 1'b1, 1'b1, 1'b0, 4'hF);
        tick();
        chk("R9 clear all", 32'(reg_rdata), 32'd0);

        // R5: drop with engine off
        drive(1'b1, 16'h1234, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        chk("R5 no write", 32'(mem_we), 32'd0);
        chk("R5 overflow flag", 32'(reg_rdata), 32'h1);
        // R9: set wins on overflow bit, other bits untouched
        drive(1'b1, 16'h1234, 16'h8000, 1'b0, 1'b1, 1'b0, 4'h1);
        tick();
        chk("R9 overflow set wins", 32'(reg_rdata), 32'h1);

        // R10/R11: mask the overflow bit
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b1, 1'b1, 4'h1);
        tick();
        chk("R10 mask loaded", 32'(reg_rdata), 32'h1);
        chk("R11 irq not yet", 32'(irq), 32'd0);
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        chk("R11 irq raised", 32'(irq), 32'd1);
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b1, 1'b0, 4'h1);
        tick();
        chk("R11 irq lags clear", 32'(irq), 32'd1);
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        chk("R11 irq dropped", 32'(irq), 32'd0);

        // random phase with address wrap near the top
        buf_base = 16'hFFFC;
        buf_len  = 12'd10;
        drive(1'b0, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] g;
            logic        en;
            case ($urandom_range(0, 3))
                0: g = 16'hFFFF;
                1: g = 16'h8000;
                2: g = 16'($urandom_range(0, 255));
                default: g = 16'($urandom);
            endcase
            en = ($urandom_range(0, 99) < 4) ? ~dma_en : dma_en;
            if (n == 0) en = 1'b1;
            drive($urandom_range(0, 9) < 7, 16'($urandom), g, en,
                  $urandom_range(0, 19) == 0, 1'($urandom), 4'($urandom));
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule